// File: doc/BRIEF.md
# Rate-Generator Down-Counter Channel

This block is a single channel of a 16-bit programmable down-counter. Software programs it through one byte-wide write port. A write flagged as control carries a packed control word. An unflagged write carries a data byte. Once a valid control word and a two-byte count have arrived, the channel produces a periodic output: a one-tick low pulse every N count ticks.

The count clock is an enable strobe, `tick_i`, that is synchronous to `clk_i`. The output changes only on clock edges that carry a tick.

Only one configuration is built: rate generation, binary counting, and the low byte loaded before the high byte. A control word asking for anything else is dropped without effect. The channel number it answers to is a parameter.

Top module: `pit_channel`

## Requirements
- R1: After reset `out_o` is 1 and the channel is stopped. Data writes made before any accepted control word are ignored, so `out_o` stays 1 under ticks.
- R2: A control write (`wr_en_i`=1, `wr_ctrl_i`=1) is accepted only if all of these fields match:
  - bits 7:6 equal `CHAN_ID`;
  - bits 5:4 equal 2'b11 (low byte then high byte);
  - bits 3:1 equal 3'b010 (rate generator);
  - bit 0 equals 0 (binary).

  With `CHAN_ID`=0 the accepted word is 8'h34.
- R3: A control word that fails R2 has no effect. Examples are 8'h74, 8'hB4, 8'h36, 8'h35 and 8'h24. Counting, the output and the position in the byte sequence are all left unchanged.
- R4: After an accepted control word, the first data write (`wr_en_i`=1, `wr_ctrl_i`=0) is the low byte of the count and the second is the high byte.
- R5: Counting starts with the first tick on a clock edge strictly after the high-byte write. A tick on the same edge as that write is not counted. Until counting starts, `out_o` is 1.
- R6: Number the ticks k = 1, 2, ... from the tick that starts counting. For a count N ≥ 2, `out_o` is 0 after tick k exactly when k mod N = 0, and 1 otherwise.
- R7: A loaded count of 0 acts as 65536: the output is low after tick 65536 only.
- R8: A loaded count of 1 drives `out_o` to 0 from tick 1 onward.
- R9: An accepted control word stops the channel and sets `out_o` to 1. The output stays 1 under ticks until a full new low/high pair is loaded. Counting then restarts as in R5.
- R10: A new low/high pair written while the channel is running does not disturb the current period. The new count takes effect at the next reload, and a lone low byte changes nothing.
- R11: On clock edges without a tick the count and `out_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-clock enable, one pulse per input clock |
| wr_en_i | input | 1 | Write strobe |
| wr_ctrl_i | input | 1 | 1: write is a control word, 0: write is a count byte |
| wr_data_i | input | 8 | Write data |
| out_o | output | 1 | Rate-generator output, low for one tick per period |

## Verification
The bench sweeps every count from 1 to 24, both with back-to-back ticks and with idle cycles between ticks. A count of 0 is run through a full 65536-tick period, because a design that compared against zero would pulse a tick early or never.

The bench loads 0x0203 as the count, with a rejected control word between the two bytes:
- A design that swapped the bytes would pulse at tick 770 instead of tick 515.
- A design that reset its byte sequence on a rejected word would never start counting.

A tick coinciding with the high-byte write must not count; a design that counted it would shift every pulse one tick early. A count reloaded mid-period must wait for the current period to end; a design that applied it at once would pulse at the wrong tick.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam logic [2:0] MODE_RATE = 3'b010;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LOHI  = 2'b11
  } access_e;

  typedef struct packed {
    logic [1:0] chan;
    access_e    access;
    logic [2:0] mode;
    logic       bcd;
  } ctrl_word_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'b00,
    SEQ_LO   = 2'b01,
    SEQ_HI   = 2'b10
  } seq_e;
endpackage

// File: rtl/pit_ctrl_dec.sv
module pit_ctrl_dec
  import pit_pkg::*;
#(
  parameter logic [1:0] CHAN_ID = 2'd0
) (
  input  logic [7:0] cw_i,
  output logic       accept_o
);
  ctrl_word_t cw;
  assign cw = ctrl_word_t'(cw_i);

  // only binary rate generation with lo/hi loading is implemented
  assign accept_o = (cw.chan == CHAN_ID) && (cw.access == ACC_LOHI) &&
                    (cw.mode == MODE_RATE) && !cw.bcd;
endmodule

// File: rtl/pit_load_seq.sv
module pit_load_seq
  import pit_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic              accept_i,
  input  logic              data_wr_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              stop_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  reload_o
);
  seq_e              seq_q;
  logic [BYTE_W-1:0] lo_q;
  logic [CNT_W-1:0]  reload_q;

  assign stop_o   = ctrl_wr_i && accept_i;
  assign done_o   = data_wr_i && (seq_q == SEQ_HI);
  assign reload_o = reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q    <= SEQ_IDLE;
      lo_q     <= '0;
      reload_q <= '0;
    end else if (stop_o) begin
      seq_q <= SEQ_LO;
    end else if (data_wr_i) begin
      unique case (seq_q)
        SEQ_LO: begin
          lo_q  <= data_i;
          seq_q <= SEQ_HI;
        end
        SEQ_HI: begin
          reload_q <= {data_i, lo_q};
          seq_q    <= SEQ_LO;
        end
        default: seq_q <= seq_q;
      endcase
    end
  end

  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && accept_i |=> seq_q == SEQ_LO);
  // R3
  ignore_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && !accept_i && !data_wr_i |=> $stable(seq_q) && $stable(reload_q) && $stable(lo_q));
  // R4
  hi_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_i && !ctrl_wr_i && seq_q == SEQ_HI |=>
      reload_q == {$past(data_i), $past(lo_q)} && seq_q == SEQ_LO);
  // R1
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_q == SEQ_IDLE && !ctrl_wr_i |=> seq_q == SEQ_IDLE);
endmodule

// File: rtl/pit_rate_core.sv
module pit_rate_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             stop_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             out_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             run_q;
  logic             primed_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      primed_q <= 1'b0;
      count_q  <= '0;
    end else if (stop_i) begin
      run_q    <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      if (done_i) run_q <= 1'b1;
      if (tick_i && run_q) begin
        // a zero reload wraps through all ones: period of 2**CNT_W
        if (!primed_q || count_q == CNT_ONE) begin
          count_q  <= reload_i;
          primed_q <= 1'b1;
        end else begin
          count_q <= count_q - CNT_ONE;
        end
      end
    end
  end

  assign out_o = !(primed_q && count_q == CNT_ONE);

  // R5
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !primed_q && tick_i && !stop_i |=> primed_q && count_q == $past(reload_i));
  // R6
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && tick_i && !stop_i && count_q == CNT_ONE |=> count_q == $past(reload_i));
  // R6
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && tick_i && !stop_i && count_q != CNT_ONE |=> count_q == $past(count_q) - CNT_ONE);
  // R9
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> out_o && !primed_q);
  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !stop_i |=> $stable(count_q) && $stable(out_o));
endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter logic [1:0]  CHAN_ID = 2'd0,
  parameter int unsigned BYTE_W  = 8,
  localparam int unsigned CNT_W  = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              wr_ctrl_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic              out_o
);
  logic             ctrl_wr, data_wr, accept, stop, done;
  logic [CNT_W-1:0] reload;
  logic [7:0]       cw;

  assign ctrl_wr = wr_en_i && wr_ctrl_i;
  assign data_wr = wr_en_i && !wr_ctrl_i;
  assign cw      = 8'(wr_data_i);

  pit_ctrl_dec #(.CHAN_ID(CHAN_ID)) i_dec (
    .cw_i     (cw),
    .accept_o (accept)
  );

  pit_load_seq #(.BYTE_W(BYTE_W)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_wr_i (ctrl_wr),
    .accept_i  (accept),
    .data_wr_i (data_wr),
    .data_i    (wr_data_i),
    .stop_o    (stop),
    .done_o    (done),
    .reload_o  (reload)
  );

  pit_rate_core #(.CNT_W(CNT_W)) i_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .stop_i   (stop),
    .done_i   (done),
    .reload_i (reload),
    .out_o    (out_o)
  );
endmodule

// File: tb/test_pit_channel.sv
module test_pit_channel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wen = 1'b0, wctl = 1'b0;
  logic [7:0] wdat = '0;
  logic       out;
  int         nvec = 0, nerr = 0, k = 0;

  always #10 clk = ~clk;

  pit_channel i_pit_channel (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wen),
    .wr_ctrl_i(wctl), .wr_data_i(wdat), .out_o(out)
  );

  function automatic bit is_low(int kk, int n);
    int p = (n == 0) ? 65536 : n;
    return (kk >= 1) && ((kk % p) == 0);
  endfunction

  task automatic chk(logic exp, string req);
    nvec++;
    if (out !== exp) begin
      nerr++;
      $display("FAIL %s: k=%0d out_o=%0b expected %0b", req, k, out, exp);
    end
  endtask

  task automatic cyc(logic t, logic we, logic wc, logic [7:0] d);
    tick = t; wen = we; wctl = wc; wdat = d;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; wen = 1'b0; wctl = 1'b0;
  endtask

  task automatic wr_ctrl(logic [7:0] b); cyc(1'b0, 1'b1, 1'b1, b); endtask
  task automatic wr_byte(logic [7:0] b); cyc(1'b0, 1'b1, 1'b0, b); endtask

  task automatic start(int n);
    logic [15:0] v = 16'(n);
    wr_ctrl(8'h34); chk(1'b1, "R9");
    wr_byte(v[7:0]); wr_byte(v[15:8]); chk(1'b1, "R5");
    k = 0;
  endtask

  task automatic ticks(int cnt, int n, int gap, string req);
    for (int i = 0; i < cnt; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 8'h00); k++;
      chk(!is_low(k, n), req);
      for (int g = 0; g < gap; g++) begin
        cyc(1'b0, 1'b0, 1'b0, 8'h00);
        chk(!is_low(k, n), "R11");
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(1'b1, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk(1'b1, "R1");
    // data before any control word is ignored
    wr_byte(8'h02); wr_byte(8'h00);
    for (int i = 0; i < 6; i++) begin cyc(1'b1, 1'b0, 1'b0, 8'h00); chk(1'b1, "R1"); end

    // sweep of small counts, dense and sparse ticks
    for (int gap = 0; gap <= 2; gap += 2)
      for (int n = 1; n <= 24; n++) begin
        start(n);
        ticks(3 * n + 3, n, gap, (n == 1) ? "R8" : "R6");
      end
    start(256); ticks(600, 256, 0, "R6");
    start(300); ticks(610, 300, 1, "R6");

    // R5: tick on the same edge as the high byte is not counted
    wr_ctrl(8'h34); wr_byte(8'h03);
    cyc(1'b1, 1'b1, 1'b0, 8'h00); chk(1'b1, "R5");
    k = 0; ticks(9, 3, 0, "R5");

    // R3: rejected words while running
    start(4); ticks(2, 4, 0, "R6");
    wr_ctrl(8'h74); wr_ctrl(8'hB4); wr_ctrl(8'h36); wr_ctrl(8'h35); wr_ctrl(8'h24);
    chk(1'b1, "R3");
    ticks(10, 4, 0, "R3");

    // R4: byte order, rejected word between the bytes (count 0x0203 = 515)
    wr_ctrl(8'h34); wr_byte(8'h03); wr_ctrl(8'h74); wr_byte(8'h02);
    chk(1'b1, "R3"); k = 0;
    ticks(520, 515, 0, "R4");

    // R9: accepted word stops the channel
    start(6); ticks(3, 6, 0, "R6");
    wr_ctrl(8'h34); chk(1'b1, "R9");
    for (int i = 0; i < 8; i++) begin cyc(1'b1, 1'b0, 1'b0, 8'h00); chk(1'b1, "R9"); end
    wr_byte(8'h07);
    for (int i = 0; i < 4; i++) begin cyc(1'b1, 1'b0, 1'b0, 8'h00); chk(1'b1, "R9"); end
    wr_byte(8'h00); k = 0;
    ticks(15, 7, 0, "R9");

    // R10: new count mid-period applies after the current period
    start(5); ticks(2, 5, 0, "R6");
    wr_byte(8'h03);
    cyc(1'b1, 1'b0, 1'b0, 8'h00); k++; chk(1'b1, "R10");
    wr_byte(8'h00);
    for (int i = 0; i < 11; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 8'h00); k++;
      chk((k <= 5) ? !(k == 5) : !(((k - 5) % 3) == 0), "R10");
    end

    // R7: zero count is a full 65536-tick period
    start(0); ticks(65538, 0, 0, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run not finished, expected completion before timeout");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule